// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A synthesizable behavioural model of a synchronous static RAM whose bus never needs an idle cycle when it switches between reads and writes. Every command (address, direction, byte selects and chip selects) is registered on a rising clock edge. Its data transfer happens on the bus exactly two enabled cycles later. Read data leave a registered output, and write data are captured at the clock edge of their data phase. Because both directions use the same two-cycle distance, a write can follow a read, or a read a write, on consecutive cycles.

Each 36-bit word has four 9-bit byte lanes. A small burst engine can continue the last loaded command over the other three words of its aligned group of four, in linear or interleaved order. An active-low clock enable freezes the whole pipeline. Three chip selects of mixed polarity gate new commands. An asynchronous output enable can switch the data drivers off at any moment. The bidirectional data bus is modelled as separate input, output and output-enable signals.

Top module: `zbtSram`

## Requirements
- R1: A read loaded at clock edge k returns mem[addr] on dataOut with dataOe high after edge k+2, when clkEnN is low at edges k, k+1 and k+2 and outEnN is low.
- R2: For a write loaded at edge k, the word on dataIn at the second enabled edge after k is stored at the command's address.
- R3: Commands of either direction may be issued on every cycle with no idle cycle between them. A read issued the cycle after a write to the same address returns the newly written data.
- R4: byteWrN is active low and is sampled with the command. byteWrN[i] low writes bits 9*i+8 down to 9*i. Lanes whose select is high keep their old contents.
- R5: While clkEnN is high, every synchronous input is ignored and all pipeline, burst and output registers hold their values, for any number of cycles.
- R6: The chip is selected only when ce1N is low, ce2 is high and ce2N is low. A deselected cycle with advLoad low starts no operation and ends any burst, while operations already in the pipeline complete.
- R7: dataOe goes low after the second enabled edge following a write command or a deselected load cycle.
- R8: outEnN high forces dataOe low at once, with no clock, and does not disturb the pipeline.
- R9: With advLoad high during an active burst, a new operation of the burst's direction starts. Its address keeps the upper bits of the loaded address. The low two bits are (base+n) mod 4 when burstInterleave is 0, or base XOR n when it is 1, where n counts the advance beats modulo 4. The byte selects are taken from the advancing cycle.
- R10: After reset no operation is in flight, dataOe is low and dataOut is zero. dataOut keeps the last word read until the next read data phase.
- R11: advLoad high while no burst is active, after reset or after a deselect, starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; high freezes the block |
| ce1N | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce2N | input | 1 | Chip select, active low |
| advLoad | input | 1 | 0 loads a new command, 1 advances the burst |
| writeN | input | 1 | Direction of a loaded command: 0 write, 1 read |
| byteWrN | input | 4 | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| burstInterleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dataIn | input | 36 | Write data bus |
| dataOut | output | 36 | Registered read data |
| dataOe | output | 1 | Data bus drive enable |

## Verification
The bench goes after the hazards of the shared two-cycle pipeline. A read placed right behind a write to the same word would return stale data if the write committed late. A write placed right behind a read would drive data into the wrong phase if the two directions had different latencies. Stalls are held for several cycles while the other inputs change, so a register that ignores clock enable would advance a command or capture the wrong write data. Deselects land in the middle of bursts and just after reads. A design that cancelled in-flight work, or kept advancing after a deselect, would show wrong data or a wrong drive enable. Bursts in both orders run past four beats to expose a wrong wrap, and partial byte selects expose a lane that is merged wrongly.

// File: rtl/zbtPkg.sv
package zbtPkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // strobes from control to datapath, valid for the current clock edge
  typedef struct packed {
    logic             advance;   // clock enable active this edge
    logic             doWrite;   // data phase of a write
    logic             doRead;    // data phase of a read
    logic [LANES-1:0] laneEn;    // lanes to update on a write
  } zbtStrobe_t;

  // low bits of a burst address for beat n
  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input logic interleave);
    return interleave ? (base ^ beat) : (base + beat);
  endfunction
endpackage

// File: rtl/zbtCtrl.sv
module zbtCtrl import zbtPkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              advLoad,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burstInterleave,
  output zbtStrobe_t        strobe,
  output logic [ADDR_W-1:0] phaseAddr
);
  typedef struct packed {
    logic              valid;
    logic              isWrite;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  laneEn;
  } pipeCmd_t;

  pipeCmd_t          nextCmd, stage1, stage2;
  logic              burstOn, burstWr;
  logic [ADDR_W-1:0] burstBase;
  logic [1:0]        burstCnt, nextBeat;
  logic              chipSel;

  assign chipSel  = !ce1N && ce2 && !ce2N;
  assign nextBeat = burstCnt + 2'd1;

  always_comb begin
    nextCmd = '0;
    if (!advLoad) begin
      if (chipSel) begin
        nextCmd.valid   = 1'b1;
        nextCmd.isWrite = !writeN;
        nextCmd.addr    = addr;
        nextCmd.laneEn  = ~byteWrN;
      end
    end else if (burstOn) begin
      nextCmd.valid   = 1'b1;
      nextCmd.isWrite = burstWr;
      nextCmd.addr    = {burstBase[ADDR_W-1:2],
                         burstLow(burstBase[1:0], nextBeat, burstInterleave)};
      nextCmd.laneEn  = ~byteWrN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1    <= '0;
      stage2    <= '0;
      burstOn   <= 1'b0;
      burstWr   <= 1'b0;
      burstBase <= '0;
      burstCnt  <= '0;
    end else if (!clkEnN) begin
      stage1 <= nextCmd;
      stage2 <= stage1;
      if (!advLoad) begin
        burstOn   <= chipSel;
        burstWr   <= !writeN;
        burstBase <= addr;
        burstCnt  <= '0;
      end else if (burstOn) begin
        burstCnt <= nextBeat;
      end
    end
  end

  always_comb begin
    strobe.advance = !clkEnN;
    strobe.doWrite = stage2.valid && stage2.isWrite;
    strobe.doRead  = stage2.valid && !stage2.isWrite;
    strobe.laneEn  = stage2.laneEn;
  end
  assign phaseAddr = stage2.addr;
endmodule

// File: rtl/zbtData.sv
module zbtData import zbtPkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  zbtStrobe_t        strobe,
  input  logic [ADDR_W-1:0] phaseAddr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] outReg;
  logic              oeReg;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (strobe.advance && strobe.doWrite && strobe.laneEn[g])
        mem[phaseAddr][g*LANE_W +: LANE_W] <= dataIn[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      oeReg  <= 1'b0;
    end else if (strobe.advance) begin
      if (strobe.doRead) outReg <= mem[phaseAddr];
      oeReg <= strobe.doRead;
    end
  end

  assign dataOut = outReg;
  assign dataOe  = oeReg && !outEnN;
endmodule

// File: rtl/zbtSram.sv
module zbtSram import zbtPkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              advLoad,
  input  logic              writeN,
  input  logic [3:0]        byteWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burstInterleave,
  input  logic              outEnN,
  input  logic [35:0]       dataIn,
  output logic [35:0]       dataOut,
  output logic              dataOe
);
  zbtStrobe_t        strobe;
  logic [ADDR_W-1:0] phaseAddr;

  zbtCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .ce1N(ce1N), .ce2(ce2),
    .ce2N(ce2N), .advLoad(advLoad), .writeN(writeN), .byteWrN(byteWrN),
    .addr(addr), .burstInterleave(burstInterleave), .strobe(strobe),
    .phaseAddr(phaseAddr)
  );

  zbtData #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phaseAddr(phaseAddr),
    .dataIn(dataIn), .outEnN(outEnN), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/zbtSramChk.sv
module zbtSramChk (
  input logic        clk,
  input logic        rstN,
  input logic        clkEnN,
  input logic        ce1N,
  input logic        ce2,
  input logic        ce2N,
  input logic        advLoad,
  input logic        writeN,
  input logic        outEnN,
  input logic [35:0] dataOut,
  input logic        dataOe
);
  logic       sel, rdCmd, wrCmd, deselCmd;
  logic [2:0] sinceRst;

  assign sel      = !ce1N && ce2 && !ce2N;
  assign rdCmd    = !clkEnN && !advLoad && sel && writeN;
  assign wrCmd    = !clkEnN && !advLoad && sel && !writeN;
  assign deselCmd = !clkEnN && !advLoad && !sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  assert_read_phase_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd3 && !outEnN && $past(rdCmd, 3) && $past(!clkEnN, 2)
     && $past(!clkEnN, 1)) |-> dataOe);

  assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd3 && ($past(wrCmd, 3) || $past(deselCmd, 3))
     && $past(!clkEnN, 2) && $past(!clkEnN, 1)) |-> !dataOe);

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(dataOut));

  always_comb begin
    if (outEnN) assert_oe_forced_off_R8: assert (!dataOe);
  end
endmodule

bind zbtSram zbtSramChk uChk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .ce1N(ce1N), .ce2(ce2),
  .ce2N(ce2N), .advLoad(advLoad), .writeN(writeN), .outEnN(outEnN),
  .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/zbtSram_test.sv
module zbtSram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic clk = 1'b0, rstN = 1'b0, clkEnN = 1'b0;
  logic ce1N = 1'b1, ce2 = 1'b0, ce2N = 1'b1, advLoad = 1'b0, writeN = 1'b1;
  logic [3:0] byteWrN = 4'hF;
  logic [AW-1:0] addr = '0;
  logic burstInterleave = 1'b0, outEnN = 1'b0;
  logic [35:0] dataIn = '0;
  logic [35:0] dataOut;
  logic dataOe;

  zbtSram #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .ce1N(ce1N), .ce2(ce2),
    .ce2N(ce2N), .advLoad(advLoad), .writeN(writeN), .byteWrN(byteWrN),
    .addr(addr), .burstInterleave(burstInterleave), .outEnN(outEnN),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  string curReq = "R10";
  logic [35:0] wd = '0;            // write data for the command being issued

  // reference model
  logic [35:0] mMem [64];
  int          pValid[$], pWrite[$], pAddr[$], pLanes[$];
  logic [35:0] expOut = '0;
  bit          expOeReg = 0;
  bit          bOn = 0, bWr = 0;
  int          bBase = 0, bCnt = 0;
  logic [35:0] wdNow[$];            // write data per enabled cycle, newest last

  task automatic modelReset();
    pValid = {0, 0}; pWrite = {0, 0}; pAddr = {0, 0}; pLanes = {0, 0};
    expOut = '0; expOeReg = 0; bOn = 0; bCnt = 0;
    wdNow = {36'h0, 36'h0};
  endtask

  task automatic modelEdge();
    bit sel;
    int nv, nw, na, nl, lo;
    if (pValid[0] != 0) begin
      if (pWrite[0] != 0) begin
        for (int l = 0; l < 4; l++)
          if (pLanes[0][l]) mMem[pAddr[0]][l*9 +: 9] = dataIn[l*9 +: 9];
        expOeReg = 0;
      end else begin
        expOut = mMem[pAddr[0]];
        expOeReg = 1;
      end
    end else expOeReg = 0;
    void'(pValid.pop_front()); void'(pWrite.pop_front());
    void'(pAddr.pop_front());  void'(pLanes.pop_front());
    sel = (ce1N == 0) && (ce2 == 1) && (ce2N == 0);
    nv = 0; nw = 0; na = 0; nl = 0;
    if (advLoad == 0) begin
      if (sel) begin nv = 1; nw = !writeN; na = int'(addr); nl = int'(~byteWrN); end
      bOn = sel; bWr = !writeN; bBase = int'(addr); bCnt = 0;
    end else if (bOn) begin
      bCnt = (bCnt + 1) % 4;
      lo = burstInterleave ? ((bBase % 4) ^ bCnt) : (((bBase % 4) + bCnt) % 4);
      nv = 1; nw = bWr; na = (bBase / 4) * 4 + lo; nl = int'(~byteWrN);
    end
    pValid.push_back(nv); pWrite.push_back(nw);
    pAddr.push_back(na);  pLanes.push_back(nl);
    wdNow.push_back(wd); void'(wdNow.pop_front());
  endtask

  task automatic check(input bit ok, input logic [35:0] act, input logic [35:0] exp,
                       input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // one clock: model at the edge, compare a quarter period later, drive at negedge
  task automatic tick();
    @(posedge clk);
    if (rstN && !clkEnN) modelEdge();
    #(CLK_PERIOD/4);
    check(dataOe === (expOeReg && !outEnN), {35'b0, dataOe},
          {35'b0, expOeReg && !outEnN}, "dataOe");
    check(dataOut === expOut, dataOut, expOut, "dataOut");
    @(negedge clk);
    dataIn = wdNow[0];   // data for the write loaded two enabled edges ago
  endtask

  task automatic setIdleFields();
    clkEnN = 0; ce1N = 0; ce2 = 1; ce2N = 0; byteWrN = 4'hF; wd = $urandom;
  endtask

  task automatic opRead(input int a);
    setIdleFields(); advLoad = 0; writeN = 1; addr = a[AW-1:0]; tick();
  endtask

  task automatic opWrite(input int a, input logic [3:0] be, input logic [35:0] d);
    setIdleFields(); advLoad = 0; writeN = 0; addr = a[AW-1:0];
    byteWrN = be; wd = d; tick();
  endtask

  task automatic opDesel(input int kind);
    setIdleFields(); advLoad = 0; writeN = $urandom; addr = $urandom;
    case (kind % 3)
      0: ce1N = 1;
      1: ce2 = 0;
      default: ce2N = 1;
    endcase
    tick();
  endtask

  task automatic opAdv(input logic [3:0] be, input logic [35:0] d);
    setIdleFields(); advLoad = 1; writeN = $urandom; addr = $urandom;
    byteWrN = be; wd = d; tick();
  endtask

  task automatic opStall();
    clkEnN = 1; ce1N = $urandom; ce2 = $urandom; ce2N = $urandom;
    advLoad = $urandom; writeN = $urandom; byteWrN = $urandom; addr = $urandom;
    tick();
  endtask

  bit finished = 0;

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    curReq = "R10";
    check(dataOe === 1'b0, {35'b0, dataOe}, 36'h0, "dataOe in reset");
    check(dataOut === 36'h0, dataOut, 36'h0, "dataOut in reset");
    rstN = 1;
    opDesel(0); opDesel(1);

    curReq = "R2";
    for (int a = 0; a < 64; a++) opWrite(a, 4'h0, {a[7:0], 28'h5A5A5A5} ^ 36'(a * 977));
    curReq = "R1";
    for (int a = 0; a < 64; a++) opRead(a);
    opDesel(0); opDesel(0);

    curReq = "R3";
    opWrite(10, 4'h0, 36'h123456789); opRead(10);
    opWrite(11, 4'h0, 36'hFEDCBA987); opRead(11); opRead(10);
    opWrite(10, 4'h0, 36'h0F0F0F0F0); opWrite(12, 4'h0, 36'h111111111);
    opRead(10); opRead(12); opWrite(13, 4'h0, 36'h222222222); opRead(13);
    opDesel(1); opDesel(2); opDesel(0);

    curReq = "R4";
    opWrite(20, 4'b1010, 36'hAAAAAAAAA); opWrite(21, 4'b0111, 36'h000000000);
    opWrite(22, 4'b1111, 36'h000000000); opRead(20); opRead(21); opRead(22);
    opDesel(0); opDesel(0);

    curReq = "R5";
    opWrite(30, 4'h0, 36'h9ABCDEF01); opStall(); opStall(); opStall();
    opRead(30); opStall(); opRead(31); opStall(); opStall(); opWrite(31, 4'h5, 36'h3C3C3C3C3);
    opStall(); opRead(31); opStall(); opDesel(0); opStall(); opDesel(0); opDesel(0);

    curReq = "R6";
    opRead(1); opDesel(0); opRead(2); opDesel(1); opWrite(3, 4'h0, 36'h777777777);
    opDesel(2); opRead(3); opDesel(0); opDesel(0);

    curReq = "R7";
    opRead(4); opRead(5); opWrite(6, 4'h0, 36'h666666666); opRead(6);
    opDesel(1); opDesel(1); opDesel(1);

    curReq = "R8";
    opRead(7); opRead(8); outEnN = 1; opRead(9); opRead(10);
    outEnN = 0; opRead(11); outEnN = 1; opDesel(0); outEnN = 0; opDesel(0); opDesel(0);

    curReq = "R9";
    burstInterleave = 0;
    opWrite(37, 4'h0, 36'h100000001);
    opAdv(4'h0, 36'h200000002); opAdv(4'h0, 36'h300000003); opAdv(4'h0, 36'h400000004);
    opRead(36); opRead(37); opRead(38); opRead(39);
    burstInterleave = 1;
    opRead(42); opAdv(4'h0, 0); opAdv(4'h0, 0); opAdv(4'h0, 0); opAdv(4'h0, 0);
    opWrite(46, 4'h0, 36'hAB0000001); opAdv(4'b1100, 36'hCD0000002); opAdv(4'h0, 36'hEF0000003);
    opRead(44); opRead(45); opRead(46); opRead(47);
    burstInterleave = 0;
    opRead(50); opAdv(4'h0, 0); opDesel(2); opAdv(4'h0, 0); opDesel(0); opDesel(0);

    curReq = "R11";
    opAdv(4'h0, 36'h0DEAD0000); opAdv(4'h0, 0); opDesel(0); opDesel(0);
    rstN = 0; @(negedge clk); modelReset(); rstN = 1;
    opAdv(4'h0, 0); opAdv(4'h0, 0); opDesel(0); opDesel(0);

    curReq = "R3";
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 6)
        0, 1: opRead($urandom % 64);
        2, 3: opWrite($urandom % 64, 4'($urandom), 36'({$urandom, $urandom}));
        4: opAdv(4'($urandom), 36'({$urandom, $urandom}));
        default: if ($urandom % 2) opStall(); else opDesel($urandom);
      endcase
    end
    opDesel(0); opDesel(0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule